// File: doc/BRIEF.md
# Vector Compare and Context Mask Unit

This block holds a per-element context mask of up to sixteen bits and keeps it current from a stream of element compares. Each compare presents two 32-bit operands, an operand kind (unsigned integer, signed integer or IEEE single-precision float), a 3-bit relation code and the index of the element it belongs to. The truth of the relation is written into that element's mask bit on the next clock edge. Bits at or above the active vector length are left alone.

The mask is consumed combinationally. A query port reports, for one element, whether an arithmetic result and a memory write may land. The answer follows a conditionalization mode that is given per query or taken from a stored default, and the mask may be read in inverted sense. A merge port picks one of two operands by the element's mask bit. A population count reports how many mask bits are set. The mask can be written out as a zero-extended data word, loaded from the low bits of a data word, and saved to or restored from a shadow buffer.

Top module: `vmask_unit`

## Requirements
- R1: After reset, every mask bit and every shadow buffer bit is 1, and the stored default mode is full gating (code 0).
- R2: For kind 0 (unsigned) and kind 1 (signed two's complement), relation code 0 is a>b, 1 is a==b, 2 is a<b, 3 is a>=b, 4 is unordered (never true for integers), 5 is a!=b, 6 is a!=b, and 7 is a<=b.
- R3: For kind 2 (float), +0 and -0 compare equal, and ordering follows the real values including infinities. When either operand is a NaN (exponent all ones, mantissa non-zero), only codes 4 and 6 are true.
- R4: A compare with cmp_valid high and cmp_idx below vlen sets mask bit cmp_idx to the relation result at the next rising edge. All other bits keep their values.
- R5: A compare whose cmp_idx is at or above vlen leaves the whole mask unchanged.
- R6: The mode codes are 0 full, 1 arithmetic only, 2 memory only and 3 always. arith_en equals the effective mask bit of qry_idx under codes 0 and 1 and is 1 otherwise. mem_en equals that bit under codes 0 and 2 and is 1 otherwise.
- R7: Query mode code 4 uses the stored default mode. A pulse on dflt_we stores dflt_mode as the new default from the next edge.
- R8: With qry_invert high, the effective mask bit used by arith_en and mem_en is the complement of the stored bit.
- R9: mrg_out equals mrg_a when mask bit mrg_idx is 1 and mrg_b when it is 0, using the true mask regardless of qry_invert.
- R10: pop_count always equals the number of 1 bits in the mask.
- R11: mask_word presents the mask in bits 15:0 with zeros above. A cycle with ld_valid loads ld_word[15:0] into the mask at the next edge, and this takes priority over a compare in the same cycle.
- R12: A cycle with save copies the mask into the shadow buffer. A cycle with restore copies the buffer into the mask at the next edge, and this takes priority over a load and over a compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid | input | 1 | Compare request strobe |
| cmp_kind | input | 2 | Operand kind: 0 unsigned, 1 signed, 2 float |
| cmp_rel | input | 3 | Relation code |
| cmp_idx | input | 4 | Element index written by the compare |
| cmp_a | input | 32 | First compare operand |
| cmp_b | input | 32 | Second compare operand |
| vlen | input | 5 | Active vector length (0 to 16) |
| dflt_we | input | 1 | Store a new default mode |
| dflt_mode | input | 2 | Default mode value (codes 0 to 3) |
| qry_mode | input | 3 | Query mode (0 to 3, or 4 for the stored default) |
| qry_idx | input | 4 | Element index for the enable query |
| qry_invert | input | 1 | Use the mask in inverted sense for the query |
| arith_en | output | 1 | Arithmetic result may be written |
| mem_en | output | 1 | Memory write may proceed |
| mrg_idx | input | 4 | Element index for the merge |
| mrg_a | input | 32 | Merge operand picked when the mask bit is 1 |
| mrg_b | input | 32 | Merge operand picked when the mask bit is 0 |
| mrg_out | output | 32 | Merge result |
| pop_count | output | 5 | Number of set mask bits |
| mask_word | output | 32 | Mask, zero-extended to a data word |
| ld_valid | input | 1 | Load the mask from ld_word |
| ld_word | input | 32 | Data word whose low bits are loaded |
| save | input | 1 | Copy the mask into the shadow buffer |
| restore | input | 1 | Copy the shadow buffer into the mask |

## Verification
The bench targets the float corners: positive versus negative zero, both infinities, quiet and signalling-pattern NaNs of either sign, and the smallest denormal. A design that compared the raw bit patterns would call zeros unequal and order negative numbers backwards. A design that mishandled NaNs would let codes 5 or 7 come out true. Compares aimed at indices beyond a shortened vector length are sent to catch a design that writes them anyway. The bench also drives compare, load and restore in the same cycle, and a wrong priority shows up as the wrong mask word. Default-mode lookup, inverted sense and merge are run against a mask of mixed ones and zeros, so a swapped mode decode or an inverted merge changes the enables or the selected operand.

// File: rtl/vmask_pkg.sv
package vmask_pkg;
  typedef enum logic [1:0] {
    KIND_UNS = 2'd0,
    KIND_SGN = 2'd1,
    KIND_FLT = 2'd2
  } kind_e;

  typedef enum logic [2:0] {
    GATE_FULL    = 3'd0,
    GATE_ARITH   = 3'd1,
    GATE_MEM     = 3'd2,
    GATE_NONE    = 3'd3,
    GATE_DEFAULT = 3'd4
  } gate_e;

  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
    logic un;
  } rel_flags_t;
endpackage

// File: rtl/vm_compare.sv
module vm_compare
  import vmask_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [1:0]               kind,
  input  logic [2:0]               rel,
  input  logic [EXP_W+MAN_W:0]     op_a,
  input  logic [EXP_W+MAN_W:0]     op_b,
  output logic                     hit
);
  localparam int DW = 1 + EXP_W + MAN_W;

  rel_flags_t int_f, flt_f, sel_f;

  logic sign_a, sign_b, nan_a, nan_b, both_zero;
  logic [DW-2:0] mag_a, mag_b;

  always_comb begin
    int_f = '0;
    if (kind_e'(kind) == KIND_SGN) begin
      int_f.gt = $signed(op_a) > $signed(op_b);
      int_f.lt = $signed(op_a) < $signed(op_b);
    end else begin
      int_f.gt = op_a > op_b;
      int_f.lt = op_a < op_b;
    end
    int_f.eq = op_a == op_b;
    int_f.un = 1'b0;
  end

  assign sign_a    = op_a[DW-1];
  assign sign_b    = op_b[DW-1];
  assign mag_a     = op_a[DW-2:0];
  assign mag_b     = op_b[DW-2:0];
  assign nan_a     = (&op_a[DW-2 -: EXP_W]) && (|op_a[MAN_W-1:0]);
  assign nan_b     = (&op_b[DW-2 -: EXP_W]) && (|op_b[MAN_W-1:0]);
  assign both_zero = (mag_a == '0) && (mag_b == '0);

  always_comb begin
    flt_f    = '0;
    flt_f.un = nan_a | nan_b;
    if (!flt_f.un) begin
      if (both_zero) begin
        flt_f.eq = 1'b1;
      end else if (sign_a != sign_b) begin
        flt_f.gt = !sign_a;
        flt_f.lt = sign_a;
      end else begin
        flt_f.eq = mag_a == mag_b;
        flt_f.gt = sign_a ? (mag_a < mag_b) : (mag_a > mag_b);
        flt_f.lt = sign_a ? (mag_a > mag_b) : (mag_a < mag_b);
      end
    end
  end

  assign sel_f = (kind_e'(kind) == KIND_FLT) ? flt_f : int_f;

  always_comb begin
    unique case (rel)
      3'd0:    hit = sel_f.gt;
      3'd1:    hit = sel_f.eq;
      3'd2:    hit = sel_f.lt;
      3'd3:    hit = sel_f.gt | sel_f.eq;
      3'd4:    hit = sel_f.un;
      3'd5:    hit = sel_f.gt | sel_f.lt;
      3'd6:    hit = sel_f.un | !sel_f.eq;
      default: hit = sel_f.lt | sel_f.eq;
    endcase
  end
endmodule

// File: rtl/vm_mask_state.sv
module vm_mask_state #(
  parameter int LANES = 16,
  parameter int DW    = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(LANES)-1:0]   wr_idx,
  input  logic                       wr_val,
  input  logic [$clog2(LANES+1)-1:0] vlen,
  input  logic                       ld_en,
  input  logic [DW-1:0]              ld_word,
  input  logic                       save,
  input  logic                       restore,
  input  logic                       dflt_we,
  input  logic [1:0]                 dflt_mode,
  output logic [LANES-1:0]           mask_q,
  output logic [1:0]                 dflt_q
);
  localparam int LEN_W = $clog2(LANES + 1);

  logic [LANES-1:0] mask_d, shadow_q, shadow_d;
  logic [1:0]       dflt_d;
  logic             in_range, mask_ce, shadow_ce, dflt_ce;

  assign in_range  = {1'b0, wr_idx} < vlen;
  assign mask_ce   = restore | ld_en | (wr_en & in_range);
  assign shadow_ce = save;
  assign dflt_ce   = dflt_we;

  always_comb begin
    mask_d = mask_q;
    if (restore) begin
      mask_d = shadow_q;
    end else if (ld_en) begin
      mask_d = ld_word[LANES-1:0];
    end else begin
      mask_d[wr_idx] = wr_val;
    end
    shadow_d = mask_q;
    dflt_d   = dflt_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '1;
      shadow_q <= '1;
      dflt_q   <= 2'd0;
    end else begin
      if (mask_ce)   mask_q   <= mask_d;
      if (shadow_ce) shadow_q <= shadow_d;
      if (dflt_ce)   dflt_q   <= dflt_d;
    end
  end

  logic unused_len;
  assign unused_len = ^{LEN_W{1'b0}};
endmodule

// File: rtl/vm_mask_use.sv
module vm_mask_use
  import vmask_pkg::*;
#(
  parameter int LANES = 16,
  parameter int DW    = 32
) (
  input  logic [LANES-1:0]           mask,
  input  logic [1:0]                 dflt,
  input  logic [2:0]                 qry_mode,
  input  logic [$clog2(LANES)-1:0]   qry_idx,
  input  logic                       qry_invert,
  input  logic [$clog2(LANES)-1:0]   mrg_idx,
  input  logic [DW-1:0]              mrg_a,
  input  logic [DW-1:0]              mrg_b,
  output logic                       arith_en,
  output logic                       mem_en,
  output logic [DW-1:0]              mrg_out,
  output logic [$clog2(LANES+1)-1:0] pop_count
);
  localparam int CNT_W = $clog2(LANES + 1);

  gate_e eff_mode;
  logic  eff_bit;

  always_comb begin
    if (gate_e'(qry_mode) == GATE_DEFAULT) eff_mode = gate_e'({1'b0, dflt});
    else                                    eff_mode = gate_e'(qry_mode);
  end

  assign eff_bit = mask[qry_idx] ^ qry_invert;

  always_comb begin
    arith_en = 1'b1;
    mem_en   = 1'b1;
    case (eff_mode)
      GATE_FULL:  begin arith_en = eff_bit; mem_en = eff_bit; end
      GATE_ARITH: arith_en = eff_bit;
      GATE_MEM:   mem_en   = eff_bit;
      default:    ;
    endcase
  end

  assign mrg_out = mask[mrg_idx] ? mrg_a : mrg_b;

  logic [CNT_W-1:0] partial [LANES+1];
  assign partial[0] = '0;
  for (genvar g = 0; g < LANES; g++) begin : g_pop
    assign partial[g+1] = partial[g] + CNT_W'(mask[g]);
  end
  assign pop_count = partial[LANES];
endmodule

// File: rtl/vmask_unit.sv
module vmask_unit #(
  parameter int LANES = 16,
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int DW    = 1 + EXP_W + MAN_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmp_valid,
  input  logic [1:0]                 cmp_kind,
  input  logic [2:0]                 cmp_rel,
  input  logic [$clog2(LANES)-1:0]   cmp_idx,
  input  logic [DW-1:0]              cmp_a,
  input  logic [DW-1:0]              cmp_b,
  input  logic [$clog2(LANES+1)-1:0] vlen,
  input  logic                       dflt_we,
  input  logic [1:0]                 dflt_mode,
  input  logic [2:0]                 qry_mode,
  input  logic [$clog2(LANES)-1:0]   qry_idx,
  input  logic                       qry_invert,
  output logic                       arith_en,
  output logic                       mem_en,
  input  logic [$clog2(LANES)-1:0]   mrg_idx,
  input  logic [DW-1:0]              mrg_a,
  input  logic [DW-1:0]              mrg_b,
  output logic [DW-1:0]              mrg_out,
  output logic [$clog2(LANES+1)-1:0] pop_count,
  output logic [DW-1:0]              mask_word,
  input  logic                       ld_valid,
  input  logic [DW-1:0]              ld_word,
  input  logic                       save,
  input  logic                       restore
);
  logic [LANES-1:0] mask_q;
  logic [1:0]       dflt_q;
  logic             cmp_hit;

  vm_compare #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cmp (
    .kind (cmp_kind),
    .rel  (cmp_rel),
    .op_a (cmp_a),
    .op_b (cmp_b),
    .hit  (cmp_hit)
  );

  vm_mask_state #(.LANES(LANES), .DW(DW)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cmp_valid),
    .wr_idx    (cmp_idx),
    .wr_val    (cmp_hit),
    .vlen      (vlen),
    .ld_en     (ld_valid),
    .ld_word   (ld_word),
    .save      (save),
    .restore   (restore),
    .dflt_we   (dflt_we),
    .dflt_mode (dflt_mode),
    .mask_q    (mask_q),
    .dflt_q    (dflt_q)
  );

  vm_mask_use #(.LANES(LANES), .DW(DW)) u_use (
    .mask       (mask_q),
    .dflt       (dflt_q),
    .qry_mode   (qry_mode),
    .qry_idx    (qry_idx),
    .qry_invert (qry_invert),
    .mrg_idx    (mrg_idx),
    .mrg_a      (mrg_a),
    .mrg_b      (mrg_b),
    .arith_en   (arith_en),
    .mem_en     (mem_en),
    .mrg_out    (mrg_out),
    .pop_count  (pop_count)
  );

  assign mask_word = {{(DW-LANES){1'b0}}, mask_q};
endmodule

// File: rtl/vmask_unit_chk.sv
module vmask_unit_chk #(
  parameter int LANES = 16,
  parameter int DW    = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cmp_valid,
  input logic [$clog2(LANES)-1:0]   cmp_idx,
  input logic [$clog2(LANES+1)-1:0] vlen,
  input logic [2:0]                 qry_mode,
  input logic                       arith_en,
  input logic                       mem_en,
  input logic [$clog2(LANES)-1:0]   mrg_idx,
  input logic [DW-1:0]              mrg_a,
  input logic [DW-1:0]              mrg_b,
  input logic [DW-1:0]              mrg_out,
  input logic [$clog2(LANES+1)-1:0] pop_count,
  input logic [DW-1:0]              mask_word,
  input logic                       ld_valid,
  input logic [DW-1:0]              ld_word,
  input logic                       restore
);
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  assert_write_one_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && ({1'b0, cmp_idx} < vlen) && !ld_valid && !restore)
      |=> (((mask_word ^ $past(mask_word)) & ~(ONE << $past(cmp_idx))) == '0));

  assert_out_of_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && ({1'b0, cmp_idx} >= vlen) && !ld_valid && !restore)
      |=> $stable(mask_word));

  assert_always_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_mode == 3'd3) |-> (arith_en && mem_en));

  assert_merge_pick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mrg_out == (mask_word[mrg_idx] ? mrg_a : mrg_b));

  assert_popcount_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pop_count == $countones(mask_word));

  assert_load_word_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !restore)
      |=> (mask_word == {{(DW-LANES){1'b0}}, $past(ld_word[LANES-1:0])}));
endmodule

bind vmask_unit vmask_unit_chk #(.LANES(LANES), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmp_valid (cmp_valid),
  .cmp_idx   (cmp_idx),
  .vlen      (vlen),
  .qry_mode  (qry_mode),
  .arith_en  (arith_en),
  .mem_en    (mem_en),
  .mrg_idx   (mrg_idx),
  .mrg_a     (mrg_a),
  .mrg_b     (mrg_b),
  .mrg_out   (mrg_out),
  .pop_count (pop_count),
  .mask_word (mask_word),
  .ld_valid  (ld_valid),
  .ld_word   (ld_word),
  .restore   (restore)
);

// File: tb/vmask_unit_test.sv
`timescale 1ns/1ps
module vmask_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_valid = 0;
  logic [1:0]  cmp_kind = 0;
  logic [2:0]  cmp_rel = 0;
  logic [3:0]  cmp_idx = 0;
  logic [31:0] cmp_a = 0, cmp_b = 0;
  logic [4:0]  vlen = 5'd16;
  logic        dflt_we = 0;
  logic [1:0]  dflt_mode = 0;
  logic [2:0]  qry_mode = 0;
  logic [3:0]  qry_idx = 0;
  logic        qry_invert = 0;
  logic        arith_en, mem_en;
  logic [3:0]  mrg_idx = 0;
  logic [31:0] mrg_a = 0, mrg_b = 0, mrg_out;
  logic [4:0]  pop_count;
  logic [31:0] mask_word;
  logic        ld_valid = 0;
  logic [31:0] ld_word = 0;
  logic        save = 0, restore = 0;

  int n_tests = 0;
  int n_fail  = 0;
  string mtag = "R1";

  always #4 clk = ~clk;

  vmask_unit uut (.*);

  logic [15:0] m_mask, m_shadow;
  int          m_dflt;

  function automatic bit is_nan(logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  function automatic longint fkey(logic [31:0] x);
    longint mag = longint'(x[30:0]);
    return x[31] ? -mag : mag;
  endfunction

  function automatic bit ref_rel(int kind, int rel, logic [31:0] a, logic [31:0] b);
    longint ka, kb;
    bit un = 0;
    if (kind == 0)      begin ka = longint'(a); kb = longint'(b); end
    else if (kind == 1) begin ka = longint'($signed(a)); kb = longint'($signed(b)); end
    else begin
      un = is_nan(a) || is_nan(b);
      ka = fkey(a); kb = fkey(b);
    end
    if (un) return (rel == 4) || (rel == 6);
    case (rel)
      0: return ka > kb;
      1: return ka == kb;
      2: return ka < kb;
      3: return ka >= kb;
      4: return 0;
      5: return ka != kb;
      6: return ka != kb;
      default: return ka <= kb;
    endcase
  endfunction

  function automatic logic [31:0] fpick(int k);
    case (k)
      0: return 32'h0000_0000;  1: return 32'h8000_0000;
      2: return 32'h3F80_0000;  3: return 32'hBF80_0000;
      4: return 32'h4000_0000;  5: return 32'hC000_0000;
      6: return 32'h7F80_0000;  7: return 32'hFF80_0000;
      8: return 32'h7FC0_0000;  9: return 32'hFFC0_0001;
      10: return 32'h0000_0001; default: return 32'h7F80_0001;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask <= 16'hFFFF; m_shadow <= 16'hFFFF; m_dflt <= 0;
    end else begin
      if (save) m_shadow <= m_mask;
      if (dflt_we) m_dflt <= int'(dflt_mode);
      if (restore) m_mask <= m_shadow;
      else if (ld_valid) m_mask <= ld_word[15:0];
      else if (cmp_valid && int'(cmp_idx) < int'(vlen))
        m_mask[cmp_idx] <= ref_rel(int'(cmp_kind), int'(cmp_rel), cmp_a, cmp_b);
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    int mode;
    bit b, ea, em;
    string qtag;
    int pc = 0;
    mode = (qry_mode == 3'd4) ? m_dflt : int'(qry_mode);
    b  = m_mask[qry_idx] ^ qry_invert;
    ea = (mode == 0 || mode == 1) ? b : 1'b1;
    em = (mode == 0 || mode == 2) ? b : 1'b1;
    qtag = (qry_mode == 3'd4) ? "R7" : (qry_invert ? "R8" : "R6");
    for (int i = 0; i < 16; i++) pc += int'(m_mask[i]);
    chk(mtag, mask_word, {16'h0, m_mask});
    chk(qtag, {30'h0, arith_en, mem_en}, {30'h0, ea, em});
    chk("R9", mrg_out, m_mask[mrg_idx] ? mrg_a : mrg_b);
    chk("R10", {27'h0, pop_count}, pc);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    check_all();
    cmp_valid = 0; ld_valid = 0; save = 0; restore = 0; dflt_we = 0;
  endtask

  task automatic do_cmp(int kind, int rel, int idx, logic [31:0] a, logic [31:0] b, string tag);
    cmp_valid = 1; cmp_kind = 2'(kind); cmp_rel = 3'(rel); cmp_idx = 4'(idx);
    cmp_a = a; cmp_b = b; mtag = tag; mrg_idx = 4'(idx);
    tick();
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    mrg_a = 32'hAAAA_0001; mrg_b = 32'h5555_0002;
    repeat (2) @(negedge clk);
    rst_n = 1;
    // R1: reset mask ones; default full -> inverted query gives 0,0
    qry_mode = 3'd4; qry_invert = 1; mtag = "R1";
    tick();
    chk("R1", {30'h0, arith_en, mem_en}, 32'h0);
    qry_invert = 0;
    // R2: integer relations
    do_cmp(0, 0, 0, 5, 3, "R2");
    do_cmp(0, 2, 1, 5, 3, "R2");
    do_cmp(1, 2, 2, 32'hFFFF_FFFF, 1, "R2");
    do_cmp(0, 2, 3, 32'hFFFF_FFFF, 1, "R2");
    do_cmp(1, 4, 11, 7, 9, "R2");
    // R3: float corners
    do_cmp(2, 1, 4, 32'h0000_0000, 32'h8000_0000, "R3");
    do_cmp(2, 4, 5, 32'h7FC0_0000, 32'h3F80_0000, "R3");
    do_cmp(2, 6, 6, 32'h3F80_0000, 32'hFFC0_0001, "R3");
    do_cmp(2, 5, 7, 32'h7FC0_0000, 32'h3F80_0000, "R3");
    do_cmp(2, 7, 8, 32'h7FC0_0000, 32'h7FC0_0000, "R3");
    do_cmp(2, 0, 9, 32'hBF80_0000, 32'h3F80_0000, "R3");
    do_cmp(2, 2, 12, 32'hC000_0000, 32'hBF80_0000, "R3");
    // R5: out-of-range index leaves mask alone
    vlen = 5'd4;
    do_cmp(0, 0, 10, 1, 2, "R5");
    do_cmp(0, 0, 4, 1, 2, "R5");
    do_cmp(0, 0, 3, 9, 2, "R4");
    vlen = 5'd16;
    // R11: load wins over compare
    ld_valid = 1; ld_word = 32'h1234_A5C3;
    do_cmp(0, 1, 0, 0, 0, "R11");
    // R12: save, load zero, then restore over a load
    save = 1; mtag = "R12"; tick();
    ld_valid = 1; ld_word = 32'h0; mtag = "R11"; tick();
    restore = 1; ld_valid = 1; ld_word = 32'hFFFF_0F0F;
    do_cmp(0, 1, 2, 0, 0, "R12");
    // R7: stored default arithmetic-only, query on a zero bit
    dflt_we = 1; dflt_mode = 2'd1; mtag = "R7"; tick();
    qry_mode = 3'd4; qry_idx = 4'd2; tick();
    qry_invert = 1; tick();
    qry_invert = 0;
    // R6 / R8: each explicit mode on zero and one bits
    for (int md = 0; md < 4; md++) begin
      for (int ix = 0; ix < 3; ix++) begin
        qry_mode = 3'(md); qry_idx = 4'(ix); qry_invert = ix[1];
        mtag = "R6"; tick();
      end
    end
    // R4/R9/R10 random traffic
    for (int n = 0; n < 400; n++) begin
      int kind = $urandom_range(0, 2);
      logic [31:0] a, b;
      if (kind == 2) begin a = fpick($urandom_range(0, 11)); b = fpick($urandom_range(0, 11)); end
      else begin a = 32'($urandom_range(0, 7)) - 32'd3; b = 32'($urandom_range(0, 7)) - 32'd3; end
      vlen = 5'($urandom_range(8, 16));
      qry_mode = 3'($urandom_range(0, 4)); qry_idx = 4'($urandom);
      qry_invert = 1'($urandom);
      mrg_a = $urandom; mrg_b = $urandom;
      ld_valid = ($urandom_range(0, 19) == 0); ld_word = $urandom;
      save = ($urandom_range(0, 15) == 0); restore = ($urandom_range(0, 23) == 0);
      dflt_we = ($urandom_range(0, 15) == 0); dflt_mode = 2'($urandom);
      cmp_valid = 1; cmp_kind = 2'(kind); cmp_rel = 3'($urandom); cmp_idx = 4'($urandom);
      cmp_a = a; cmp_b = b; mrg_idx = 4'($urandom);
      mtag = (kind == 2) ? "R3" : "R4";
      tick();
    end
    finish_run();
  end
endmodule